// File: doc/BRIEF.md
# Local Interrupt Entry Bank with Source Trigger

This block holds the seven local interrupt entries of one interrupt controller: timer, thermal sensor, performance counter, local pin 0, local pin 1, internal error and corrected machine check. Software reaches the entries through a simple register port addressed by byte offset. Each entry stores a vector, a delivery mode and a mask, plus whatever extra control bits its type allows. Bits that an entry does not keep are dropped on write.

A separate trigger port names one local source by index. On a trigger strobe the block reads that source's entry and decides what to deliver. A fixed-mode entry with a legal vector gives an interrupt request carrying that vector. A fixed-mode entry with a vector below 16 gives an illegal-vector error strobe instead. An NMI-mode entry gives a non-maskable interrupt request. A masked entry, and any other delivery mode, gives nothing. An index with no entry gives an invalid-argument pulse. All results are registered single-cycle pulses that appear one cycle after the strobe.

Top module: `lvt_bank`

## Requirements
- R1: After reset every one of the seven entries reads 0x0001_0000, with only the mask bit (bit 16) set.
- R2: Entry offsets are: machine check 0x2F0, timer 0x320, thermal 0x330, performance 0x340, pin 0 0x350, pin 1 0x360, error 0x370. A read of any other offset returns zero, and a write to any other offset changes no entry.
- R3: Field layout is vector [7:0], delivery mode [10:8], delivery status [12], polarity [13], remote IRR [14], trigger mode [15], mask [16], timer mode [17]. Every entry keeps vector, delivery status and mask. The timer entry also keeps timer mode. Pin 0 and pin 1 also keep delivery mode, polarity, remote IRR and trigger mode. Thermal, performance and machine check also keep delivery mode. The error entry keeps nothing more. Every other bit reads back as zero.
- R4: While `sw_enable` is low, any entry write is stored with the mask bit set.
- R5: Trigger indexes are timer 0, thermal 1, performance 2, pin 0 3, pin 1 4, error 5, machine check 6. Triggering an entry whose mask bit is set produces no output.
- R6: Delivery mode 000 (fixed) with a vector of 16 or more produces a one-cycle `irq_valid` pulse carrying that vector in `irq_vector`, in the cycle after the strobe.
- R7: Fixed mode with a vector below 16 produces no interrupt. Instead `err_valid` pulses for one cycle with `err_code` equal to 0x20 (bit 5, send illegal vector).
- R8: Delivery mode 100 produces a one-cycle `nmi_valid` pulse.
- R9: Any delivery mode other than 000 and 100 produces no output.
- R10: The timer and error sources always deliver in fixed mode, even when the written delivery-mode bits ask for something else.
- R11: Trigger index 7 produces a one-cycle `trig_bad` pulse and nothing else.
- R12: When an entry is written in the same cycle that it is triggered, the trigger uses the contents from before the write, and the write is still stored.
- R13: Outputs pulse only in the cycle after a strobe, and at most one of `irq_valid`, `nmi_valid`, `err_valid` and `trig_bad` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_enable | input | 1 | Controller software-enable; low forces the mask bit on writes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (12) | Byte offset for read and write |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr` (combinational) |
| trig_valid | input | 1 | Local source trigger strobe |
| trig_src | input | SRC_W (3) | Index of the source to fire |
| irq_valid | output | 1 | Fixed interrupt request pulse |
| irq_vector | output | 8 | Vector of the interrupt request |
| nmi_valid | output | 1 | Non-maskable interrupt request pulse |
| err_valid | output | 1 | Illegal-vector error pulse |
| err_code | output | ERR_W (8) | Error code, bit 5 for send illegal vector |
| trig_bad | output | 1 | Invalid source index pulse |

## Verification
A register write and a trigger can land on the same entry in the same clock cycle. The bench provokes this by writing an NMI-mode value into pin 0 while firing pin 0 in that same cycle, after pin 0 had been set up for a fixed vector. It then expects the old fixed-vector request, followed by an NMI from the next trigger and a read-back of the new value. Back-to-back triggers on different sources in consecutive cycles are also checked, so that each one yields exactly one pulse in its own cycle.

// File: rtl/lvt_pkg.sv
package lvt_pkg;

   // Stored entry field positions
   localparam int VEC_LSB   = 0;
   localparam int VEC_W     = 8;
   localparam int DM_LSB    = 8;
   localparam int DM_W      = 3;
   localparam int DS_BIT    = 12;
   localparam int POL_BIT   = 13;
   localparam int RIRR_BIT  = 14;
   localparam int TRIG_BIT  = 15;
   localparam int MASK_BIT  = 16;
   localparam int TMODE_BIT = 17;
   localparam int ENTRY_W   = 18;

   localparam int NUM_SRC   = 7;
   localparam int MIN_VEC   = 16;
   localparam int ERR_ILLEGAL_SEND_BIT = 5;

   localparam logic [DM_W-1:0] DM_FIXED = 3'b000;
   localparam logic [DM_W-1:0] DM_NMI   = 3'b100;

   typedef enum logic [2:0] {
      SRC_TIMER = 3'd0,
      SRC_THERM = 3'd1,
      SRC_PERF  = 3'd2,
      SRC_PIN0  = 3'd3,
      SRC_PIN1  = 3'd4,
      SRC_ERROR = 3'd5,
      SRC_MCHK  = 3'd6
   } src_e;

   localparam logic [ENTRY_W-1:0] RESET_ENTRY = ENTRY_W'(1) << MASK_BIT;

   function automatic logic [ENTRY_W-1:0] base_keep();
      logic [ENTRY_W-1:0] m;
      m = '0;
      m[VEC_LSB +: VEC_W] = '1;
      m[DS_BIT]   = 1'b1;
      m[MASK_BIT] = 1'b1;
      return m;
   endfunction

   // Bits an entry retains from a write
   function automatic logic [ENTRY_W-1:0] keep_mask(input int src);
      logic [ENTRY_W-1:0] m;
      m = base_keep();
      case (src)
         int'(SRC_TIMER): m[TMODE_BIT] = 1'b1;
         int'(SRC_ERROR): ;
         int'(SRC_PIN0), int'(SRC_PIN1): begin
            m[DM_LSB +: DM_W] = '1;
            m[POL_BIT]  = 1'b1;
            m[RIRR_BIT] = 1'b1;
            m[TRIG_BIT] = 1'b1;
         end
         default: m[DM_LSB +: DM_W] = '1;
      endcase
      return m;
   endfunction

   // Byte offset of each entry
   function automatic logic [11:0] entry_offset(input int src);
      logic [11:0] off;
      if (src == int'(SRC_MCHK))
         off = 12'h2F0;
      else
         off = 12'h320 + 12'(src * 16);
      return off;
   endfunction

   function automatic logic fixed_only(input int src);
      return (src == int'(SRC_TIMER)) || (src == int'(SRC_ERROR));
   endfunction

endpackage

// File: rtl/lvt_decode.sv
module lvt_decode
   import lvt_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_SRC-1:0] sel
);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
      localparam logic [ADDR_W-1:0] OFF = ADDR_W'(entry_offset(i));
      assign sel[i] = (addr == OFF);
   end

endmodule

// File: rtl/lvt_entry.sv
module lvt_entry
   import lvt_pkg::*;
#(
   parameter logic [ENTRY_W-1:0] KEEP = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic               sw_enable,
   input  logic [ENTRY_W-1:0] wdata,
   output logic [ENTRY_W-1:0] q
);

   logic [ENTRY_W-1:0] force_bits;
   logic [ENTRY_W-1:0] next_q;

   always_comb begin
      force_bits = '0;
      force_bits[MASK_BIT] = ~sw_enable;
      next_q = (wdata & KEEP) | force_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RESET_ENTRY;
      else if (wr)
         q <= next_q;
   end

endmodule

// File: rtl/lvt_fire.sv
module lvt_fire
   import lvt_pkg::*;
#(
   parameter int SRC_W = 3,
   parameter int ERR_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       trig_valid,
   input  logic [SRC_W-1:0]           trig_src,
   input  logic [NUM_SRC*ENTRY_W-1:0] entries,
   output logic                       irq_valid,
   output logic [VEC_W-1:0]           irq_vector,
   output logic                       nmi_valid,
   output logic                       err_valid,
   output logic [ERR_W-1:0]           err_code,
   output logic                       trig_bad
);

   localparam logic [ERR_W-1:0] ERR_SEND = ERR_W'(1) << ERR_ILLEGAL_SEND_BIT;

   logic [ENTRY_W-1:0] cur;
   logic               in_range;
   logic               force_fixed;
   logic [DM_W-1:0]    mode;
   logic [VEC_W-1:0]   vec;
   logic               do_irq, do_nmi, do_err;

   always_comb begin
      cur         = '0;
      in_range    = 1'b0;
      force_fixed = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (trig_src == SRC_W'(i)) begin
            cur         = entries[i*ENTRY_W +: ENTRY_W];
            in_range    = 1'b1;
            force_fixed = fixed_only(i);
         end
      end
      mode = force_fixed ? DM_FIXED : cur[DM_LSB +: DM_W];
      vec  = cur[VEC_LSB +: VEC_W];
      do_irq = 1'b0;
      do_nmi = 1'b0;
      do_err = 1'b0;
      if (trig_valid && in_range && !cur[MASK_BIT]) begin
         case (mode)
            DM_FIXED: begin
               if (vec < VEC_W'(MIN_VEC)) do_err = 1'b1;
               else                       do_irq = 1'b1;
            end
            DM_NMI:  do_nmi = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid  <= 1'b0;
         irq_vector <= '0;
         nmi_valid  <= 1'b0;
         err_valid  <= 1'b0;
         err_code   <= '0;
         trig_bad   <= 1'b0;
      end else begin
         irq_valid  <= do_irq;
         irq_vector <= do_irq ? vec : '0;
         nmi_valid  <= do_nmi;
         err_valid  <= do_err;
         err_code   <= do_err ? ERR_SEND : '0;
         trig_bad   <= trig_valid && !in_range;
      end
   end

endmodule

// File: rtl/lvt_bank.sv
module lvt_bank
   import lvt_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int SRC_W  = 3,
   parameter int ERR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_enable,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              trig_valid,
   input  logic [SRC_W-1:0]  trig_src,
   output logic              irq_valid,
   output logic [7:0]        irq_vector,
   output logic              nmi_valid,
   output logic              err_valid,
   output logic [ERR_W-1:0]  err_code,
   output logic              trig_bad
);

   // Elaboration checks
   if (ADDR_W < 10) begin : g_chk_addr
      $error("lvt_bank: ADDR_W must reach offset 0x370");
   end
   if (DATA_W <= ENTRY_W) begin : g_chk_data
      $error("lvt_bank: DATA_W must exceed the stored entry width");
   end
   if (SRC_W < 3) begin : g_chk_src
      $error("lvt_bank: SRC_W must encode all sources");
   end
   if (ERR_W <= ERR_ILLEGAL_SEND_BIT) begin : g_chk_err
      $error("lvt_bank: ERR_W too narrow for the error code");
   end

   logic [NUM_SRC-1:0]         sel;
   logic [NUM_SRC*ENTRY_W-1:0] entries;
   logic [ENTRY_W-1:0]         rd_or [NUM_SRC+1];

   lvt_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (reg_addr),
      .sel  (sel)
   );

   assign rd_or[0] = '0;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_ent
      logic [ENTRY_W-1:0] q;
      lvt_entry #(.KEEP(keep_mask(i))) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr        (reg_wr && sel[i]),
         .sw_enable (sw_enable),
         .wdata     (reg_wdata[ENTRY_W-1:0]),
         .q         (q)
      );
      assign entries[i*ENTRY_W +: ENTRY_W] = q;
      assign rd_or[i+1] = rd_or[i] | (sel[i] ? q : '0);
   end

   assign reg_rdata = DATA_W'(rd_or[NUM_SRC]);

   lvt_fire #(.SRC_W(SRC_W), .ERR_W(ERR_W)) u_fire (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_valid (trig_valid),
      .trig_src   (trig_src),
      .entries    (entries),
      .irq_valid  (irq_valid),
      .irq_vector (irq_vector),
      .nmi_valid  (nmi_valid),
      .err_valid  (err_valid),
      .err_code   (err_code),
      .trig_bad   (trig_bad)
   );

endmodule

// File: rtl/lvt_bank_chk.sv
module lvt_bank_chk #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int SRC_W  = 3,
   parameter int ERR_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_enable,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              trig_valid,
   input logic [SRC_W-1:0]  trig_src,
   input logic              irq_valid,
   input logic [7:0]        irq_vector,
   input logic              nmi_valid,
   input logic              err_valid,
   input logic [ERR_W-1:0]  err_code,
   input logic              trig_bad
);

   localparam int LIVE_W = 18;

   // R3: bits above the stored layout and bit 11 always read zero
   a_r3_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[DATA_W-1:LIVE_W] == '0) && !reg_rdata[11]);

   // R4: a write while disabled leaves the mask set on read-back
   a_r4_forced_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !sw_enable) ##1 $stable(reg_addr) |-> (reg_rdata[16] || reg_rdata == '0));

   // R6: an interrupt request never carries a reserved vector
   a_r6_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (irq_vector >= 8'd16));

   // R7: the error pulse carries the send-illegal-vector code
   a_r7_err_code: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> (err_code == (ERR_W'(1) << 5)));

   // R11: an undefined index yields the invalid-argument pulse
   a_r11_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_valid && (trig_src >= SRC_W'(7))) |=> trig_bad);

   // R13: at most one result per cycle
   a_r13_one_result: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_valid, nmi_valid, err_valid, trig_bad}));

   // R13: a result only follows a strobe
   a_r13_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid || nmi_valid || err_valid || trig_bad) |-> $past(trig_valid));

endmodule

bind lvt_bank lvt_bank_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .ERR_W(ERR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sw_enable  (sw_enable),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_rdata  (reg_rdata),
   .trig_valid (trig_valid),
   .trig_src   (trig_src),
   .irq_valid  (irq_valid),
   .irq_vector (irq_vector),
   .nmi_valid  (nmi_valid),
   .err_valid  (err_valid),
   .err_code   (err_code),
   .trig_bad   (trig_bad)
);

// File: tb/lvt_bank_test.sv
`timescale 1ns/1ps
module lvt_bank_test;

   localparam int K_NONE = 0;
   localparam int K_IRQ  = 1;
   localparam int K_NMI  = 2;
   localparam int K_ERR  = 3;
   localparam int K_BAD  = 4;

   typedef struct {
      int         kind;
      logic [7:0] vec;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_enable = 1'b1;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        trig_valid = 1'b0;
   logic [2:0]  trig_src = '0;
   logic        irq_valid;
   logic [7:0]  irq_vector;
   logic        nmi_valid;
   logic        err_valid;
   logic [7:0]  err_code;
   logic        trig_bad;

   int checks = 0;
   int fails  = 0;
   exp_t q[$];
   logic trig_seen = 1'b0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   lvt_bank uut (
      .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .trig_valid(trig_valid), .trig_src(trig_src),
      .irq_valid(irq_valid), .irq_vector(irq_vector), .nmi_valid(nmi_valid),
      .err_valid(err_valid), .err_code(err_code), .trig_bad(trig_bad)
   );

   always @(posedge clk) trig_seen <= trig_valid;

   // Monitor: compare results against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (trig_seen) begin
            exp_t e;
            bit ok;
            logic [7:0] got_vec;
            if (q.size() == 0) begin
               e.kind = K_NONE; e.vec = '0; e.tag = "R13";
            end else begin
               e = q.pop_front();
            end
            ok = (irq_valid == (e.kind == K_IRQ)) && (nmi_valid == (e.kind == K_NMI)) &&
                 (err_valid == (e.kind == K_ERR)) && (trig_bad == (e.kind == K_BAD));
            if (e.kind == K_IRQ) ok = ok && (irq_vector == e.vec);
            if (e.kind == K_ERR) ok = ok && (err_code == 8'h20);
            got_vec = irq_vector;
            checks++;
            if (!ok) begin
               fails++;
               $display("FAIL %s: got irq=%0b vec=%02h nmi=%0b err=%0b code=%02h bad=%0b, expected kind=%0d vec=%02h",
                        e.tag, irq_valid, got_vec, nmi_valid, err_valid, err_code, trig_bad, e.kind, e.vec);
            end
         end else if (irq_valid || nmi_valid || err_valid || trig_bad) begin
            checks++;
            fails++;
            $display("FAIL R13: pulse without strobe irq=%0b nmi=%0b err=%0b bad=%0b, expected none",
                     irq_valid, nmi_valid, err_valid, trig_bad);
         end
      end
   end

   task automatic step(input bit w, input logic [11:0] a, input logic [31:0] d,
                       input bit t, input logic [2:0] s, input int k,
                       input logic [7:0] v, input string tag);
      exp_t e;
      @(negedge clk);
      reg_wr = w; reg_addr = a; reg_wdata = d;
      trig_valid = t; trig_src = s;
      if (t) begin
         e.kind = k; e.vec = v; e.tag = tag;
         q.push_back(e);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      step(1'b1, a, d, 1'b0, 3'd0, K_NONE, 8'h00, "");
   endtask

   task automatic trg(input logic [2:0] s, input int k, input logic [7:0] v, input string tag);
      step(1'b0, 12'h000, 32'h0, 1'b1, s, k, v, tag);
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_wr = 1'b0; trig_valid = 1'b0; reg_addr = a;
      #1;
      checks++;
      if (reg_rdata !== exp) begin
         fails++;
         $display("FAIL %s: read %03h got %08h expected %08h", tag, a, reg_rdata, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      reg_wr = 1'b0; trig_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset value in every entry
      rd(12'h2F0, 32'h0001_0000, "R1");
      rd(12'h320, 32'h0001_0000, "R1");
      rd(12'h330, 32'h0001_0000, "R1");
      rd(12'h340, 32'h0001_0000, "R1");
      rd(12'h350, 32'h0001_0000, "R1");
      rd(12'h360, 32'h0001_0000, "R1");
      rd(12'h370, 32'h0001_0000, "R1");
      // R2: non-entry offsets read zero
      rd(12'h300, 32'h0, "R2");
      rd(12'h380, 32'h0, "R2");

      // R3: per-entry kept bits
      wr(12'h320, 32'hFFFF_FFFF);
      wr(12'h330, 32'hFFFF_FFFF);
      wr(12'h340, 32'hFFFF_FFFF);
      wr(12'h350, 32'hFFFF_FFFF);
      wr(12'h360, 32'hFFFF_FFFF);
      wr(12'h370, 32'hFFFF_FFFF);
      wr(12'h2F0, 32'hFFFF_FFFF);
      rd(12'h320, 32'h0003_10FF, "R3");
      rd(12'h330, 32'h0001_17FF, "R3");
      rd(12'h340, 32'h0001_17FF, "R3");
      rd(12'h350, 32'h0001_F7FF, "R3");
      rd(12'h360, 32'h0001_F7FF, "R3");
      rd(12'h370, 32'h0001_10FF, "R3");
      rd(12'h2F0, 32'h0001_17FF, "R3");

      // R2: writes to other offsets change nothing
      wr(12'h300, 32'h0000_0000);
      wr(12'h310, 32'h0000_0000);
      rd(12'h300, 32'h0, "R2");
      rd(12'h320, 32'h0003_10FF, "R2");
      rd(12'h2F0, 32'h0001_17FF, "R2");

      // R4 / R5: disabled write forces mask, masked entry is silent
      sw_enable = 1'b0;
      wr(12'h330, 32'h0000_0031);
      rd(12'h330, 32'h0001_0031, "R4");
      trg(3'd1, K_NONE, 8'h00, "R5");
      idle();
      sw_enable = 1'b1;

      // R6: fixed delivery with a legal vector
      wr(12'h330, 32'h0000_0031);
      rd(12'h330, 32'h0000_0031, "R4");
      trg(3'd1, K_IRQ, 8'h31, "R6");
      idle();
      // R6 boundary: vector 16 is legal
      wr(12'h2F0, 32'h0000_0010);
      trg(3'd6, K_IRQ, 8'h10, "R6");
      // R7 boundary: vector 15 refused
      wr(12'h2F0, 32'h0000_000F);
      trg(3'd6, K_ERR, 8'h00, "R7");
      idle();

      // R8: NMI mode
      wr(12'h340, 32'h0000_0400);
      trg(3'd2, K_NMI, 8'h00, "R8");
      idle();

      // R9: other delivery modes ignored
      wr(12'h360, 32'h0000_0720);
      trg(3'd4, K_NONE, 8'h00, "R9");
      wr(12'h350, 32'h0000_0220);
      trg(3'd3, K_NONE, 8'h00, "R9");
      idle();

      // R10: timer and error always fixed
      wr(12'h320, 32'h0000_0455);
      rd(12'h320, 32'h0000_0055, "R10");
      trg(3'd0, K_IRQ, 8'h55, "R10");
      wr(12'h370, 32'h0000_0403);
      trg(3'd5, K_ERR, 8'h00, "R10");
      wr(12'h370, 32'h0000_0480);
      trg(3'd5, K_IRQ, 8'h80, "R10");
      idle();

      // R11: undefined index
      trg(3'd7, K_BAD, 8'h00, "R11");
      idle();

      // R12: same-cycle write and trigger of one entry
      wr(12'h350, 32'h0000_0040);
      step(1'b1, 12'h350, 32'h0000_0450, 1'b1, 3'd3, K_IRQ, 8'h40, "R12");
      trg(3'd3, K_NMI, 8'h00, "R12");
      rd(12'h350, 32'h0000_0450, "R12");

      // R13: back-to-back triggers on different sources
      trg(3'd0, K_IRQ, 8'h55, "R13");
      trg(3'd2, K_NMI, 8'h00, "R13");
      trg(3'd1, K_IRQ, 8'h31, "R13");
      trg(3'd7, K_BAD, 8'h00, "R13");
      idle();
      idle();
      idle();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule